// File: doc/BRIEF.md
# Addressed Multi-Channel DAC Serial Loader

This block receives words over a three-wire serial link and keeps the digital codes for a bank of converter channels. The host drives an active-low frame-select, a serial clock and a data line. Each frame carries a channel number and then a code, most significant bit first. The block writes the code into the register of that channel. It also pulses an update strobe for that channel, which the analog stage uses to start a new conversion. A broadcast input makes one frame load the same code into every channel, for example to set zero or full scale during calibration.

The serial pins are not used as clocks. They pass through two-flop synchronizers into a system clock that runs at least four times faster than the serial clock. Edges are then detected from the synchronized samples. A bit counter sets the frame length. Only a fresh falling edge of frame-select arms it. Clock edges after the last bit are ignored, and a frame cut short by frame-select rising is dropped. An active-low reset clears every channel to code zero at once, and it is released in step with the system clock. The host board should tie the reset pin high with a pull-up, so that an undriven pin leaves the block running.

Top module: `dac_serial_loader`

## Requirements
- R1: A frame is 19 bits sent most significant bit first. The first 5 bits are the channel number (bit 4 first) and the last 14 bits are the code, in straight binary. A complete frame loads the code into the register of that channel, which drives `ch_code[ch*14 +: 14]`. All other channels keep their values.
- R2: A bit is taken only on a falling edge of `sclk` while `frame_n` is low. Toggling `sclk` while `frame_n` is high has no effect. This holds whether the serial clock runs all the time or only during frames.
- R3: A frame starts only on a falling edge of `frame_n` seen after `frame_n` was high. If `frame_n` is already low when reset is released, it does not start a frame, and `sclk` edges that follow load nothing.
- R4: After the 19th bit, further `sclk` falling edges are ignored until `frame_n` rises and falls again. Extra bits do not change the written value and do not cause a second write.
- R5: If `frame_n` rises before the 19th bit, the partial frame is discarded. No register changes and no strobe fires.
- R6: If `bcast` is high when the 19th bit is taken, the code goes into all 32 channels and every strobe pulses. The channel number in that frame is ignored.
- R7: `ch_upd[i]` goes high for exactly one system clock cycle, in the same cycle that channel i shows its new code. This happens four system clock cycles after the `sclk` fall that carries bit 19 reaches the pin. In any cycle, `ch_upd` is all zeros, has exactly one bit set, or is all ones.
- R8: While `rst_n` is low, every channel reads zero and every strobe is low, with no clock edge needed. A frame in progress is abandoned.
- R9: A channel value changes only in a cycle in which a strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock rate |
| rst_n | input | 1 | Asynchronous active-low reset, released in step with the system clock |
| frame_n | input | 1 | Serial frame select, active low |
| sclk | input | 1 | Serial clock; data is taken on its falling edge |
| sdata | input | 1 | Serial data, most significant bit first |
| bcast | input | 1 | When high at the end of a frame, the code goes to all channels |
| ch_code | output | 448 | Channel codes, 14 bits per channel, channel 0 in the lowest bits |
| ch_upd | output | 32 | One-cycle update strobe per channel |

## Verification
A fault in the bit counter or the frame state shows at the ports within a frame. It appears as a code written to the wrong channel, as a shifted code, as a write when a frame was cut short, or as a second strobe caused by extra clock edges. Each of these shows in `ch_code` and `ch_upd` four cycles after the last serial bit would have completed. A fault in the edge detection or the reset values of the synchronizers shows as a spurious write when reset is released with frame-select held low. A broken channel decode shows as a strobe pattern that is neither one-hot nor all ones, in the same cycle as the write.

// File: rtl/dsl_pkg.sv
package dsl_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_SHIFT = 2'd1,
    RX_FULL  = 2'd2
  } rx_state_t;
endpackage

// File: rtl/dsl_sync.sv
module dsl_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/dsl_frame_rx.sv
module dsl_frame_rx
  import dsl_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int CODE_W  = 14,
  localparam int FRAME_W = ADDR_W + CODE_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fs_n,
  input  logic              sck,
  input  logic              sd,
  input  logic              bc,
  output logic              wr_en,
  output logic              wr_all,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [CODE_W-1:0] wr_code,
  output logic [CNT_W-1:0]  bit_cnt
);
  rx_state_t          state;
  logic               fs_q, sck_q;
  logic [FRAME_W-2:0] shreg;
  logic [FRAME_W-1:0] word;
  logic               fs_fall, sck_fall;

  // Both samples reset low so a select held low across reset is never an edge.
  assign fs_fall  = fs_q & ~fs_n;
  assign sck_fall = sck_q & ~sck;
  assign word     = {shreg, sd};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      fs_q    <= 1'b0;
      sck_q   <= 1'b0;
      shreg   <= '0;
      bit_cnt <= '0;
      wr_en   <= 1'b0;
      wr_all  <= 1'b0;
      wr_addr <= '0;
      wr_code <= '0;
    end else begin
      fs_q  <= fs_n;
      sck_q <= sck;
      wr_en <= 1'b0;
      unique case (state)
        RX_IDLE: begin
          if (fs_fall) begin
            state   <= RX_SHIFT;
            bit_cnt <= '0;
          end
        end
        RX_SHIFT: begin
          if (fs_n) begin
            state <= RX_IDLE;                 // short frame dropped
          end else if (sck_fall) begin
            shreg <= word[FRAME_W-2:0];
            if (bit_cnt == CNT_W'(FRAME_W - 1)) begin
              state   <= RX_FULL;
              bit_cnt <= CNT_W'(FRAME_W);
              wr_en   <= 1'b1;
              wr_all  <= bc;
              wr_addr <= word[FRAME_W-1 -: ADDR_W];
              wr_code <= word[CODE_W-1:0];
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
        end
        RX_FULL: begin
          if (fs_n) state <= RX_IDLE;         // wait for a fresh select
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dsl_chan_bank.sv
module dsl_chan_bank #(
  parameter int NUM_CH = 32,
  parameter int ADDR_W = 5,
  parameter int CODE_W = 14
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     wr_all,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [CODE_W-1:0]        wr_code,
  output logic [NUM_CH*CODE_W-1:0] codes,
  output logic [NUM_CH-1:0]        upd
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic              hit;
    logic [CODE_W-1:0] code_q;

    assign hit = wr_en && (wr_all || (wr_addr == ADDR_W'(g)));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q <= '0;
        upd[g] <= 1'b0;
      end else begin
        upd[g] <= hit;
        if (hit) code_q <= wr_code;
      end
    end

    assign codes[g*CODE_W +: CODE_W] = code_q;
  end
endmodule

// File: rtl/dac_serial_loader.sv
module dac_serial_loader #(
  parameter int NUM_CH      = 32,
  parameter int CODE_W      = 14,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W  = $clog2(NUM_CH),
  localparam int FRAME_W = ADDR_W + CODE_W,
  localparam int CNT_W   = $clog2(FRAME_W + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     frame_n,
  input  logic                     sclk,
  input  logic                     sdata,
  input  logic                     bcast,
  output logic [NUM_CH*CODE_W-1:0] ch_code,
  output logic [NUM_CH-1:0]        ch_upd
);
  logic              rst_int_n;
  logic [3:0]        pin_s;
  logic              wr_en, wr_all;
  logic [ADDR_W-1:0] wr_addr;
  logic [CODE_W-1:0] wr_code;
  logic [CNT_W-1:0]  rx_bit_cnt;

  // Reset: asserted at once, released after SYNC_STAGES clock edges.
  dsl_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_int_n)
  );

  dsl_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0000)) u_pin_sync (
    .clk(clk), .rst_n(rst_int_n),
    .d({bcast, sdata, sclk, frame_n}), .q(pin_s)
  );

  dsl_frame_rx #(.ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_rx (
    .clk(clk), .rst_n(rst_int_n),
    .fs_n(pin_s[0]), .sck(pin_s[1]), .sd(pin_s[2]), .bc(pin_s[3]),
    .wr_en(wr_en), .wr_all(wr_all), .wr_addr(wr_addr), .wr_code(wr_code),
    .bit_cnt(rx_bit_cnt)
  );

  dsl_chan_bank #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CODE_W(CODE_W)) u_bank (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(wr_en), .wr_all(wr_all), .wr_addr(wr_addr), .wr_code(wr_code),
    .codes(ch_code), .upd(ch_upd)
  );
endmodule

// File: rtl/dac_serial_loader_chk.sv
module dac_serial_loader_chk #(
  parameter int NUM_CH  = 32,
  parameter int CODE_W  = 14,
  parameter int FRAME_W = 19,
  parameter int CNT_W   = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [NUM_CH*CODE_W-1:0] ch_code,
  input logic [NUM_CH-1:0]        ch_upd,
  input logic [CNT_W-1:0]         bit_cnt
);
  assert_upd_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($onehot0(ch_upd) || (&ch_upd)));

  assert_upd_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_upd) |=> !(|ch_upd));

  assert_code_needs_upd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ch_code) |-> (|ch_upd));

  assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_W'(FRAME_W));

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_clear_R8: assert (ch_code == '0 && ch_upd == '0);
    end
  end
endmodule

bind dac_serial_loader dac_serial_loader_chk #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_code(ch_code), .ch_upd(ch_upd),
  .bit_cnt(rx_bit_cnt)
);

// File: tb/dac_serial_loader_test.sv
`timescale 1ns/1ps
module dac_serial_loader_test;
  localparam int NCH = 32;
  localparam int CW  = 14;
  localparam int NV  = 8;
  // {mode[21:20], bcast[19], chan[18:14], code[13:0]}; mode 0 plain, 1 extra bits, 2 cut short
  localparam logic [21:0] VEC [NV] = '{
    {2'd0, 1'b0, 5'd5,  14'h1234},
    {2'd0, 1'b0, 5'd0,  14'h3FFF},
    {2'd0, 1'b0, 5'd31, 14'h0001},
    {2'd1, 1'b0, 5'd12, 14'h2AAA},
    {2'd2, 1'b0, 5'd7,  14'h0BAD},
    {2'd0, 1'b1, 5'd3,  14'h1555},
    {2'd0, 1'b0, 5'd31, 14'h2000},
    {2'd0, 1'b0, 5'd16, 14'h0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic frame_n = 1'b1, sclk = 1'b0, sdata = 1'b0, bcast = 1'b0;
  logic [NCH*CW-1:0] ch_code;
  logic [NCH-1:0]    ch_upd;

  int n_chk = 0, n_fail = 0;
  int upd_cycles = 0;
  logic [NCH-1:0] upd_mask = '0;
  logic [CW-1:0]  mdl [NCH];

  always #2.5 clk = ~clk;

  dac_serial_loader uut (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .sclk(sclk),
    .sdata(sdata), .bcast(bcast), .ch_code(ch_code), .ch_upd(ch_upd)
  );

  always @(negedge clk) begin
    if (|ch_upd) begin
      upd_cycles++;
      upd_mask |= ch_upd;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_val(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic check_codes(input string req);
    int bad;
    bad = -1;
    for (int c = 0; c < NCH; c++)
      if (bad < 0 && ch_code[c*CW +: CW] !== mdl[c]) bad = c;
    n_chk++;
    if (bad >= 0) begin
      n_fail++;
      $display("FAIL %s: channel %0d actual 0x%0h expected 0x%0h",
               req, bad, ch_code[bad*CW +: CW], mdl[bad]);
    end
  endtask

  task automatic clear_mon();
    upd_cycles = 0;
    upd_mask = '0;
  endtask

  task automatic send_frame(input logic [31:0] w, input int nbits, input bit release_fs);
    frame_n = 1'b0;
    tick(4);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdata = w[i];
      sclk  = 1'b1;
      tick(4);
      sclk  = 1'b0;
      tick(4);
    end
    tick(4);
    if (release_fs) frame_n = 1'b1;
    tick(12);
  endtask

  task automatic run_all();
    for (int c = 0; c < NCH; c++) mdl[c] = '0;
    tick(1);
    rst_n = 1'b0;
    tick(4);
    rst_n = 1'b1;
    clear_mon();
    tick(20);
    // R8 reset state
    check_codes("R8 reset clears codes");
    check_val("R8 no strobe after reset", 64'(upd_cycles), 64'd0);

    // table of vectors
    for (int v = 0; v < NV; v++) begin
      logic [21:0] e;
      logic [1:0]  mode;
      logic [NCH-1:0] emask;
      string tag;
      e = VEC[v];
      mode = e[21:20];
      bcast = e[19];
      clear_mon();
      if (mode == 2'd1)      send_frame({9'd0, e[18:0], 4'hF}, 23, 1'b1);
      else if (mode == 2'd2) send_frame({22'd0, e[18:9]}, 10, 1'b1);
      else                   send_frame({13'd0, e[18:0]}, 19, 1'b1);
      bcast = 1'b0;
      if (mode == 2'd2) begin
        emask = '0;
        tag = "R5";
      end else if (e[19]) begin
        emask = '1;
        for (int c = 0; c < NCH; c++) mdl[c] = e[13:0];
        tag = "R6";
      end else begin
        emask = NCH'(1) << e[18:14];
        mdl[e[18:14]] = e[13:0];
        tag = (mode == 2'd1) ? "R4" : "R1";
      end
      check_codes({tag, " channel codes"});
      check_val({tag, " R7 strobe mask"}, 64'(upd_mask), 64'(emask));
      check_val({tag, " R7 strobe cycles"}, 64'(upd_cycles), (mode == 2'd2) ? 64'd0 : 64'd1);
    end

    // R2: clock activity with select high, as with a free-running clock
    clear_mon();
    for (int i = 0; i < 25; i++) begin
      sdata = i[0];
      sclk = 1'b1;
      tick(4);
      sclk = 1'b0;
      tick(4);
    end
    tick(8);
    check_codes("R2 clock with select high leaves codes");
    check_val("R2 R9 no strobe with select high", 64'(upd_cycles), 64'd0);

    // R8: reset in the middle of a frame clears at once
    send_frame({22'd0, 5'd9, 5'd0}, 10, 1'b0);
    rst_n = 1'b0;
    #1;
    for (int c = 0; c < NCH; c++) mdl[c] = '0;
    check_codes("R8 asynchronous clear mid-frame");
    check_val("R8 strobes low in reset", 64'(ch_upd), 64'd0);
    tick(3);
    rst_n = 1'b1;
    tick(6);

    // R3: select held low across reset release starts nothing
    clear_mon();
    send_frame({13'd0, 5'd9, 14'h0777}, 19, 1'b1);
    check_codes("R3 no frame without fresh select edge");
    check_val("R3 no strobe without fresh select edge", 64'(upd_cycles), 64'd0);

    clear_mon();
    send_frame({13'd0, 5'd9, 14'h0777}, 19, 1'b1);
    mdl[9] = 14'h0777;
    check_codes("R3 frame after fresh select edge");
    check_val("R3 R7 strobe after fresh select edge", 64'(upd_mask), 64'(NCH'(1) << 9));

    // R4: extra bits while select stays low, then a second frame
    clear_mon();
    send_frame({9'd0, 5'd20, 14'h1111, 4'h0}, 23, 1'b1);
    mdl[20] = 14'h1111;
    check_codes("R4 trailing zeros ignored");
    check_val("R4 single write", 64'(upd_cycles), 64'd1);
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run incomplete (actual timeout, expected finish)");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule